// File: doc/BRIEF.md
# Zero-Suppressed Channel Digitization Sequencer

This block runs the conversion sequence for a 32-channel front-end readout after each event. A discriminator bitmap arrives with a start pulse. A set bit means that channel crossed threshold. The sequencer converts only the flagged channels. It takes them from the lowest index upward and stops right after the highest flagged one. The time spent per event therefore grows with the number of hits, not with the channel count.

For every visited channel the block makes two conversions: first the charge value, then the timing value. For each conversion it does three things:

- It places the channel number and a charge/time selector on the converter control lines and raises a one-cycle convert strobe.
- It waits a fixed number of clock cycles, set by a parameter.
- It captures the converter result and emits it as a tagged word made of the channel number, the selector and the data.

After the last word, a one-cycle done strobe marks the end of the event. While an event is in progress the block reports busy, and it ignores any new start pulse.

Top module: `zsup_digitize_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `word_valid_o` and `adc_convert_o` are all low, and they stay low until a start is accepted.
- R2: A start pulse taken while idle latches `hit_map_i`. Exactly the channels whose bit is set are converted, each with exactly two strobes and two words. The charge word (selector 0) comes before the time word (selector 1).
- R3: Flagged channels are visited in strictly ascending index order.
- R4: The output word is `{channel[4:0], selector, data[DW-1:0]}`: the channel sits in the top five bits, the selector in bit DW, and the data in bits DW-1:0. The data is the value of `adc_data_i` sampled CONV_CYC+1 cycles after the cycle in which the strobe was high.
- R5: `adc_convert_o` is high for one cycle per conversion. `adc_chan_o` and `adc_kind_o` hold steady from the strobe until the result is captured.
- R6: `done_o` pulses exactly once per event. It rises 2 + H*(2*CONV_CYC+5) cycles after the edge that accepted the start, where H is the number of set bits. This count does not depend on where the hits lie, so no channel above the highest hit is scanned.
- R7: An all-zero bitmap produces no strobe and no word, only the done pulse, two cycles after the start.
- R8: `busy_o` rises on the edge that accepts a start and falls in the cycle `done_o` is high. A start pulse while busy changes neither the words nor the event length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin an event |
| hit_map_i | input | NCH | Above-threshold flags, bit n for channel n |
| adc_data_i | input | DW | Converter result |
| adc_chan_o | output | CHW | Channel under conversion |
| adc_kind_o | output | 1 | 0 = charge, 1 = time conversion |
| adc_convert_o | output | 1 | One-cycle convert strobe |
| word_valid_o | output | 1 | Output word valid |
| word_o | output | CHW+1+DW | Tagged result word |
| busy_o | output | 1 | Event in progress |
| done_o | output | 1 | End-of-event strobe |

## Verification
The bench first sweeps a single hit over all 32 positions. This separates the handling of the lowest and highest channels, and it shows that event length does not depend on a hit's position. Hit patterns of three and four channels check ordering and the charge/time interleave. Pairs mirrored across the map, alternating bits, every bit set and pseudo-random maps expose mistakes in clearing bits and in the find-next logic. An empty map checks the no-conversion path. One run pulses start mid-event with a different map, which must leave the words and the timing unchanged. The converter model in the bench holds a garbage value until the exact capture cycle, so a capture taken early or late is caught.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PICK = 3'd1,
    S_CONV = 3'd2,
    S_WAIT = 3'd3,
    S_CAPT = 3'd4,
    S_FIN  = 3'd5
  } zs_state_e;

  localparam logic KIND_CHARGE = 1'b0;
  localparam logic KIND_TIME   = 1'b1;

  // Cycles from accepted start to done for a given hit count
  function automatic int unsigned zs_event_cycles(input int unsigned hits,
                                                  input int unsigned conv);
    return 2 + hits * (2 * conv + 5);
  endfunction
endpackage

// File: rtl/zs_lsb_pick.sv
module zs_lsb_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign onehot_o = vec_i & (~vec_i + N'(1));
  assign found_o  = |vec_i;

  always_comb begin
    a_onehot_r3: assert ($onehot0(onehot_o));
  end
endmodule

// File: rtl/zs_conv_timer.sv
module zs_conv_timer #(
  parameter int CYC = 4,
  parameter int CW  = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign expire_o = (cnt_q == CW'(1));

  // R5: a new conversion never restarts a running interval
  p_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> cnt_q == '0);
endmodule

// File: rtl/zs_word_reg.sv
module zs_word_reg #(
  parameter int CHW = 5,
  parameter int DW  = 12,
  parameter int WW  = CHW + 1 + DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capt_i,
  input  logic [CHW-1:0] chan_i,
  input  logic           kind_i,
  input  logic [DW-1:0]  data_i,
  output logic           valid_o,
  output logic [WW-1:0]  word_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= capt_i;
      if (capt_i) word_o <= {chan_i, kind_i, data_i};
    end
  end

  // R4: words are single-cycle pulses, one per capture
  p_word_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: rtl/zsup_digitize_seq.sv
module zsup_digitize_seq #(
  parameter int NCH      = 32,
  parameter int DW       = 12,
  parameter int CONV_CYC = 4,
  localparam int CHW     = $clog2(NCH),
  localparam int WW      = CHW + 1 + DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [NCH-1:0] hit_map_i,
  input  logic [DW-1:0]  adc_data_i,
  output logic [CHW-1:0] adc_chan_o,
  output logic           adc_kind_o,
  output logic           adc_convert_o,
  output logic           word_valid_o,
  output logic [WW-1:0]  word_o,
  output logic           busy_o,
  output logic           done_o
);
  import zs_pkg::*;

  zs_state_e      st_q;
  logic [NCH-1:0] rem_q;
  logic [CHW-1:0] chan_q;
  logic           kind_q;
  logic           busy_q;
  logic           done_q;

  logic           pick_found;
  logic [CHW-1:0] pick_idx;
  logic [NCH-1:0] pick_onehot;
  logic           conv_expire;

  // named internal events
  logic start_take, pick_fire, series_end, conv_fire, capt_fire;
  assign start_take = start_i && (st_q == S_IDLE);
  assign pick_fire  = (st_q == S_PICK) && pick_found;
  assign series_end = (st_q == S_PICK) && !pick_found;
  assign conv_fire  = (st_q == S_CONV);
  assign capt_fire  = (st_q == S_CAPT);

  zs_lsb_pick #(.N(NCH), .IW(CHW)) u_pick (
    .vec_i   (rem_q),
    .found_o (pick_found),
    .idx_o   (pick_idx),
    .onehot_o(pick_onehot)
  );

  zs_conv_timer #(.CYC(CONV_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (conv_fire),
    .expire_o(conv_expire)
  );

  zs_word_reg #(.CHW(CHW), .DW(DW)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .capt_i (capt_fire),
    .chan_i (chan_q),
    .kind_i (kind_q),
    .data_i (adc_data_i),
    .valid_o(word_valid_o),
    .word_o (word_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      chan_q <= '0;
      kind_q <= KIND_CHARGE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == S_FIN);
      unique case (st_q)
        S_IDLE: if (start_take) begin
          rem_q  <= hit_map_i;
          busy_q <= 1'b1;
          st_q   <= S_PICK;
        end
        S_PICK: if (pick_found) begin
          chan_q <= pick_idx;
          kind_q <= KIND_CHARGE;
          rem_q  <= rem_q & ~pick_onehot;
          st_q   <= S_CONV;
        end else begin
          st_q <= S_FIN;
        end
        S_CONV: st_q <= S_WAIT;
        S_WAIT: if (conv_expire) st_q <= S_CAPT;
        S_CAPT: if (kind_q == KIND_CHARGE) begin
          kind_q <= KIND_TIME;
          st_q   <= S_CONV;
        end else begin
          st_q <= S_PICK;
        end
        S_FIN: begin
          busy_q <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign adc_chan_o    = chan_q;
  assign adc_kind_o    = kind_q;
  assign adc_convert_o = conv_fire;
  assign busy_o        = busy_q;
  assign done_o        = done_q;

  // R5: strobe lasts one cycle
  p_conv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convert_o |=> !adc_convert_o);
  // R5: select lines steady while the converter works
  p_sel_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT || st_q == S_CAPT) |-> $stable(adc_chan_o) && $stable(adc_kind_o));
  // R2: conversions and words only inside an event
  p_conv_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_convert_o || word_valid_o) |-> busy_o);
  // R2: each pick retires exactly one flagged channel
  p_rem_shrinks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_fire |=> $countones(rem_q) == $countones($past(rem_q)) - 1);
  // R3: next channel lies above the one just finished
  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_fire && $past(st_q) == S_CAPT) |-> pick_idx > chan_q);
  // R6: an exhausted map ends the series at once
  p_series_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    series_end |=> !adc_convert_o ##1 done_o);
  // R8: busy falls only together with done
  p_busy_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R8: a start during an event leaves the remaining map alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st_q != S_IDLE && st_q != S_PICK) |=> rem_q == $past(rem_q));
endmodule

// File: tb/zsup_digitize_seq_test.sv
`timescale 1ns/1ps
module zsup_digitize_seq_test;
  localparam int NCH = 32;
  localparam int DW  = 12;
  localparam int W   = 4;
  localparam int CHW = 5;
  localparam int WW  = CHW + 1 + DW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [NCH-1:0] hit_map_i = '0;
  logic [DW-1:0]  adc_data_i = '0;
  logic [CHW-1:0] adc_chan_o;
  logic           adc_kind_o, adc_convert_o, word_valid_o, busy_o, done_o;
  logic [WW-1:0]  word_o;

  zsup_digitize_seq #(.NCH(NCH), .DW(DW), .CONV_CYC(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_map_i(hit_map_i),
    .adc_data_i(adc_data_i), .adc_chan_o(adc_chan_o), .adc_kind_o(adc_kind_o),
    .adc_convert_o(adc_convert_o), .word_valid_o(word_valid_o), .word_o(word_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] resp(input int ch, input int kind);
    return DW'(ch * 37 + kind * 1000 + 5);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // converter model: garbage until the exact capture cycle
  int conv_n = 0, pend_left = 0, rch = 0, rk = 0;
  always @(negedge clk) begin
    if (adc_convert_o) begin
      conv_n++;
      adc_data_i = '1;
      pend_left = W + 1;
      rch = int'(adc_chan_o);
      rk = int'(adc_kind_o);
    end else if (pend_left > 0) begin
      pend_left--;
      if (pend_left == 0) adc_data_i = resp(rch, rk);
    end
  end

  logic [WW-1:0] exp_q [64];
  int exp_n = 0, got_n = 0, done_n = 0, last_ch = -1;
  always @(negedge clk) begin
    if (word_valid_o) begin
      if (got_n < exp_n)
        check(word_o == exp_q[got_n], "R4 word content", longint'(word_o), longint'(exp_q[got_n]));
      else
        check(1'b0, "R2 extra word", got_n + 1, exp_n);
      if (word_o[DW] == 1'b0) begin
        check(int'(word_o[WW-1 -: CHW]) > last_ch, "R3 ascending channel",
              longint'(word_o[WW-1 -: CHW]), last_ch + 1);
        last_ch = int'(word_o[WW-1 -: CHW]);
      end
      got_n++;
    end
    if (done_o) done_n++;
  end

  task automatic run_event(input logic [NCH-1:0] map, input bit poke);
    int lat, k, t, h;
    lat = 2; h = 0; exp_n = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (map[ch]) begin
        exp_q[exp_n] = {CHW'(ch), 1'b0, resp(ch, 0)}; exp_n++;
        exp_q[exp_n] = {CHW'(ch), 1'b1, resp(ch, 1)}; exp_n++;
        lat += 1 + 2 * (W + 2);
        h++;
      end
    end
    @(negedge clk);
    got_n = 0; done_n = 0; last_ch = -1; conv_n = 0;
    hit_map_i = map; start_i = 1'b1;
    @(posedge clk); #1 k = cyc;
    @(negedge clk);
    start_i = 1'b0; hit_map_i = ~map;
    check(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    if (poke && h > 0) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; hit_map_i = '1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 5000) begin @(negedge clk); t++; end
    if (!done_o) check(1'b0, "R6 done timeout", t, lat);
    else begin
      check(cyc - k == lat, "R6 latency", cyc - k, lat);
      check(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
    end
    repeat (3) @(negedge clk);
    check(got_n == exp_n, "R2 word count", got_n, exp_n);
    check(conv_n == 2 * h, (h == 0) ? "R7 no strobes on empty map" : "R2 strobe count", conv_n, 2 * h);
    check(done_n == 1, "R6 single done", done_n, 1);
    check(busy_o == 1'b0, "R8 idle after event", busy_o, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R6 watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && word_valid_o == 0 && adc_convert_o == 0,
          "R1 outputs in reset", {busy_o, done_o, word_valid_o, adc_convert_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && word_valid_o == 0 && adc_convert_o == 0,
          "R1 idle after reset", {busy_o, done_o, word_valid_o, adc_convert_o}, 0);

    run_event(32'h8001_8002, 1'b0);            // 1,15,16,31
    run_event(32'h8001_8000, 1'b0);            // 15,16,31
    run_event(32'h8000_8002, 1'b0);            // 1,15,31
    run_event(32'h8001_0002, 1'b0);            // 1,16,31
    run_event('0, 1'b0);                       // R7 empty map
    run_event(32'h8001_8002, 1'b1);            // R8 start while busy
    run_event('1, 1'b0);
    run_event(32'h5555_5555, 1'b0);
    for (int i = 0; i < NCH; i++) run_event(NCH'(1) << i, 1'b0);
    for (int i = 0; i < NCH / 2; i++) run_event((NCH'(1) << i) | (NCH'(1) << (NCH - 1 - i)), 1'b0);
    lfsr = 32'hACE1_1357;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_event(lfsr, i[0]);
    end
    finish_run();
  end
endmodule